// File: doc/BRIEF.md
# Serial NRZI Output Encoder

This block turns a stream of 10-bit parallel words into one serial bit per bit-rate clock enable. It emits the bits least significant first. Each word is taken from a one-word holding register that a word strobe fills. A fresh word enters the shift path on every tenth bit tick.

The serial stream can pass through an x+1 differential stage, in which each line bit is the previous line bit XOR the current data bit. That stage is controlled by an active-low select and by nothing else. When the select is left undriven, the stage is on.

A lock-status input models the upstream clock multiplier. While lock is absent, every counter and shift register holds, and the serial output does not toggle. During reset the output enable is low and all state clears.

Top module: `serial_nrzi_encoder`

## Requirements
- R1: While `rst` is high, `sdo` is 0 and `sdo_oe` is 0. `sdo_oe` reads 1 from the first clock edge after `rst` falls.
- R2: Each clock edge with `bit_en` and `locked` both high is one bit tick. Each tick puts exactly one data bit on `sdo`, and the bits of a word go out in order bit 0 to bit 9.
- R3: `word_stb` high captures `word_in` into the holding register in any cycle. The holding register is copied into the shift path on the first tick after reset and then on every tenth tick. If `word_stb` is high on that load tick, the word on `word_in` is the one sent.
- R4: With `nrzi_sel_n` = 0, each tick sets `sdo` to its previous value XOR the current data bit.
- R5: With `nrzi_sel_n` = 1, each tick sets `sdo` equal to the current data bit.
- R6: An undriven (high-impedance) `nrzi_sel_n` behaves as 0, so the differential stage is on.
- R7: While `locked` is 0, `sdo`, the bit position and the shift contents do not change. Once lock returns, the word resumes at the bit where it stopped.
- R8: A clock edge with `bit_en` low changes neither `sdo` nor the bit position.
- R9: The differential history resets to 0, so the first tick after reset with the stage on gives `sdo` equal to the data bit.
- R10: The bit position counter only takes the values 0 to 9 and returns to 0 after 9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-rate clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_en | input | 1 | Bit tick enable |
| word_in | input | 10 | Parallel data word |
| word_stb | input | 1 | Captures `word_in` |
| nrzi_sel_n | input | 1 | Low (or undriven) selects the differential stage |
| locked | input | 1 | Upstream clock lock status |
| sdo | output | 1 | Serial line bit |
| sdo_oe | output | 1 | Output enable for the line driver |

## Verification
The load tick can coincide with a word strobe. If it does, the word on the input bus must win over the stale held word. The bench provokes this by raising the strobe in exactly the tick cycle where its own model expects bit 0. It then compares all ten following line bits against the new word. A second collision pairs a lock loss with an active `bit_en`: the bench asserts both together for several cycles, requires `sdo` to stay flat, and then requires the word to resume from the saved bit.

// File: rtl/ser_enc_pkg.sv
package ser_enc_pkg;

    localparam int DEF_WORD_W = 10;

    typedef struct packed {
        logic line;
        logic oe;
    } line_state_t;

    // Undriven or low select turns the differential stage on.
    function automatic logic diff_active(input logic sel_n);
        return (sel_n !== 1'b1);
    endfunction

    function automatic logic line_next(input logic prev, input logic dbit, input logic diff_on);
        return diff_on ? (prev ^ dbit) : dbit;
    endfunction

endpackage

// File: rtl/ser_bit_counter.sv
module ser_bit_counter #(
    parameter int WORD_W = ser_enc_pkg::DEF_WORD_W,
    localparam int CW = $clog2(WORD_W)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick,
    output logic          load,
    output logic [CW-1:0] pos
);
    localparam logic [CW-1:0] LAST = CW'(WORD_W - 1);

    always_ff @(posedge clk) begin
        if (rst)
            pos <= '0;
        else if (tick)
            pos <= (pos == LAST) ? '0 : pos + 1'b1;
    end

    assign load = (pos == '0);

    assert_pos_range_R10: assert property (@(posedge clk) disable iff (rst)
        pos <= LAST);
    assert_pos_wrap_R10: assert property (@(posedge clk) disable iff (rst)
        (tick && pos == LAST) |=> pos == '0);
    assert_pos_idle_R8: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(pos));
endmodule

// File: rtl/ser_word_shifter.sv
module ser_word_shifter #(
    parameter int WORD_W = ser_enc_pkg::DEF_WORD_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              load,
    input  logic [WORD_W-1:0] word_in,
    input  logic              word_stb,
    output logic              dbit
);
    logic [WORD_W-1:0] hold_q;
    logic [WORD_W-1:0] shift_q;
    logic [WORD_W-1:0] cur;

    always_ff @(posedge clk) begin
        if (rst)
            hold_q <= '0;
        else if (word_stb)
            hold_q <= word_in;
    end

    always_comb begin
        if (load)
            cur = word_stb ? word_in : hold_q;
        else
            cur = shift_q;
    end

    always_ff @(posedge clk) begin
        if (rst)
            shift_q <= '0;
        else if (tick)
            shift_q <= cur >> 1;
    end

    assign dbit = cur[0];

    assert_shift_frozen_R7: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(shift_q));
endmodule

// File: rtl/ser_line_stage.sv
module ser_line_stage (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic dbit,
    input  logic sel_n,
    output logic line,
    output logic oe
);
    import ser_enc_pkg::*;

    line_state_t st_q;
    logic        diff_on;

    assign diff_on = diff_active(sel_n);

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q.oe <= 1'b1;
            if (tick)
                st_q.line <= line_next(st_q.line, dbit, diff_on);
        end
    end

    assign line = st_q.line;
    assign oe   = st_q.oe;

    assert_oe_low_R1: assert property (@(posedge clk)
        rst |=> (!oe && !line));
    assert_diff_step_R4: assert property (@(posedge clk) disable iff (rst)
        (tick && sel_n == 1'b0) |=> line == ($past(line) ^ $past(dbit)));
    assert_pass_step_R5: assert property (@(posedge clk) disable iff (rst)
        (tick && sel_n == 1'b1) |=> line == $past(dbit));
    assert_line_frozen_R7: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(line));
endmodule

// File: rtl/serial_nrzi_encoder.sv
module serial_nrzi_encoder #(
    parameter int WORD_W = ser_enc_pkg::DEF_WORD_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bit_en,
    input  logic [WORD_W-1:0] word_in,
    input  logic              word_stb,
    input  logic              nrzi_sel_n,
    input  logic              locked,
    output logic              sdo,
    output logic              sdo_oe
);
    localparam int CW = $clog2(WORD_W);

    logic          tick;
    logic          load;
    logic          dbit;
    logic [CW-1:0] pos;

    assign tick = bit_en & locked;

    ser_bit_counter #(.WORD_W(WORD_W)) u_cnt (
        .clk (clk),
        .rst (rst),
        .tick(tick),
        .load(load),
        .pos (pos)
    );

    ser_word_shifter #(.WORD_W(WORD_W)) u_shift (
        .clk     (clk),
        .rst     (rst),
        .tick    (tick),
        .load    (load),
        .word_in (word_in),
        .word_stb(word_stb),
        .dbit    (dbit)
    );

    ser_line_stage u_line (
        .clk  (clk),
        .rst  (rst),
        .tick (tick),
        .dbit (dbit),
        .sel_n(nrzi_sel_n),
        .line (sdo),
        .oe   (sdo_oe)
    );

    assert_unlocked_static_R7: assert property (@(posedge clk) disable iff (rst)
        !locked |=> $stable(sdo));
endmodule

// File: tb/serial_nrzi_encoder_test.sv
module serial_nrzi_encoder_test;
    logic       clk = 0;
    logic       rst = 1;
    logic       bit_en = 0;
    logic [9:0] word_in = '0;
    logic       word_stb = 0;
    logic       nrzi_sel_n = 0;
    logic       locked = 1;
    logic       sdo;
    logic       sdo_oe;

    int total = 0;
    int bad = 0;

    logic [9:0] m_hold = '0;
    logic [9:0] m_word = '0;
    int         m_idx = 0;
    logic       m_prev = 0;
    logic       m_diff = 1;

    always #2 clk = ~clk;

    serial_nrzi_encoder uut (
        .clk(clk), .rst(rst), .bit_en(bit_en), .word_in(word_in),
        .word_stb(word_stb), .nrzi_sel_n(nrzi_sel_n), .locked(locked),
        .sdo(sdo), .sdo_oe(sdo_oe)
    );

    task automatic check(input string req, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
        end
    endtask

    // One clock edge with the given controls, then a check of sdo.
    task automatic step(input logic en, input logic lk, input logic stb,
                        input logic [9:0] w, input string req);
        logic b;
        @(negedge clk);
        bit_en = en; locked = lk; word_stb = stb; word_in = w;
        @(posedge clk);
        #1;
        if (en && lk) begin
            if (m_idx == 0) m_word = stb ? w : m_hold;
            b = m_word[m_idx];
            m_prev = m_diff ? (m_prev ^ b) : b;
            m_idx = (m_idx + 1) % 10;
        end
        if (stb) m_hold = w;
        check(req, sdo, m_prev);
        bit_en = 0; word_stb = 0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1; bit_en = 0; word_stb = 0; locked = 1;
        repeat (3) @(posedge clk);
        #1;
        check("R1 sdo in reset", sdo, 1'b0);
        check("R1 oe in reset", sdo_oe, 1'b0);
        @(negedge clk);
        rst = 0;
        @(posedge clk);
        #1;
        check("R1 oe after reset", sdo_oe, 1'b1);
        m_hold = '0; m_word = '0; m_idx = 0; m_prev = 0;
    endtask

    task automatic send_word(input logic [9:0] w, input string req);
        step(1, 1, 1, w, req);
        for (int i = 1; i < 10; i++) step(1, 1, 0, '0, req);
    endtask

    task automatic t_reset_history();
        nrzi_sel_n = 0; m_diff = 1;
        do_reset();
        step(1, 1, 1, 10'h001, "R9 first bit equals data");
        check("R9 first line bit", sdo, 1'b1);
        for (int i = 1; i < 10; i++) step(1, 1, 0, '0, "R9");
    endtask

    task automatic t_diff_words();
        nrzi_sel_n = 0; m_diff = 1;
        send_word(10'h2A5, "R4 R2 R3 collide load");
        send_word(10'h3FF, "R4 all ones");
        send_word(10'h001, "R4 R10 single one");
    endtask

    task automatic t_pass_words();
        nrzi_sel_n = 1; m_diff = 0;
        send_word(10'h155, "R5 R2 alternating");
        send_word(10'h0F0, "R5 block");
    endtask

    task automatic t_prestrobe();
        nrzi_sel_n = 0; m_diff = 1;
        step(0, 1, 1, 10'h1C3, "R3 strobe idle cycle");
        step(0, 1, 1, 10'h0B7, "R3 second strobe overrides");
        for (int i = 0; i < 10; i++) step(1, 1, 0, 10'h3FF, "R3 held word");
    endtask

    task automatic t_lock_loss();
        logic s;
        nrzi_sel_n = 0; m_diff = 1;
        step(1, 1, 1, 10'h26D, "R7 pre-loss");
        for (int i = 1; i < 4; i++) step(1, 1, 0, '0, "R7 pre-loss");
        s = sdo;
        for (int i = 0; i < 5; i++) step(1, 0, 0, '0, "R7 static while unlocked");
        check("R7 unchanged level", sdo, s);
        for (int i = 4; i < 10; i++) step(1, 1, 0, '0, "R7 resume");
        send_word(10'h3A1, "R7 next word aligned");
    endtask

    task automatic t_idle();
        nrzi_sel_n = 1; m_diff = 0;
        step(1, 1, 1, 10'h2B4, "R8 start");
        step(1, 1, 0, '0, "R8");
        for (int i = 0; i < 4; i++) step(0, 1, 0, '0, "R8 no tick");
        for (int i = 2; i < 10; i++) step(1, 1, 0, '0, "R8 continue");
    endtask

    task automatic t_undriven();
        nrzi_sel_n = 1'bz; m_diff = 1;
        send_word(10'h19E, "R6 undriven select");
        nrzi_sel_n = 0;
    endtask

    initial begin
        fork
            begin
                t_reset_history();
                t_diff_words();
                t_pass_words();
                t_prestrobe();
                t_lock_loss();
                t_idle();
                t_undriven();
                t_reset_history();
            end
            begin
                repeat (20000) @(posedge clk);
                total++; bad++;
                $display("FAIL watchdog actual=running expected=done");
            end
        join_any
        disable fork;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule